// File: doc/BRIEF.md
# Logged Sync Object Table

This block keeps a table of sequence counters, one per sync object, each selected by a small handle that indexes a single device-wide table. Several command engines share it. Each engine has a wait port and a signal port. A wait request names a handle and a 32-bit target sequence, and its done flag stays low until the stored value reaches the target. A signal request names a handle, a new 32-bit value and the virtual memory identifier (VMID) of the writer. The only way to change an entry is through a signal request.

Anyone may read the table through a read port. That port returns the stored value and the identity of the last writer of the entry. Every served signal is appended to a record FIFO that a privileged monitor drains. Each record carries the engine, the VMID, the handle, the value, a suspicious-value flag and a permission-refused flag. A run-time switch selects between two modes. In the checked mode, a per-VMID write mask gates each write. In the fast mode, every write is applied and only the records are relied on. When the record FIFO is full, signal requests are held off rather than dropped, and a stall counter counts the cycles lost.

Top module: `sync_obj_table`

## Requirements
- R1: After reset every entry reads 0 with last engine 0 and last VMID 0, `log_valid` is 0, `ovf_cnt` is 0 and no `sig_ready` bit is set.
- R2: The read port returns, in the same cycle, the stored value, last engine and last VMID of the entry at `rd_handle`, for any handle.
- R3: `wait_done[e]` is 1 exactly when `wait_valid[e]` is 1 and the stored value of `wait_handle[e]` is greater than or equal to `wait_seq[e]`, compared unsigned.
- R4: A signal is served in a cycle where its `sig_valid` and `sig_ready` bits are both 1. From the next cycle the entry holds the new value, and the serving engine index and VMID are recorded as its last writer.
- R5: At most one signal is served per cycle. Among the engines with `sig_valid` set, the one with the lowest index is served first, and records appear in the order of service.
- R6: Each served signal adds exactly one record to the FIFO, and records leave in arrival order. A record is removed on a cycle with `log_valid` and `log_ready` both 1, and nothing else removes it. The record fields are the engine, VMID, handle, value, `log_viol` and `log_denied`.
- R7: `log_viol` is 1 when the value is unsigned-lower than the entry's value before the write, or when it equals 0x00000000, 0xFFFFFFFF or 0xDEADBEEF. A flagged write that is permitted is still applied.
- R8: With `check_en` = 1, a signal whose VMID bit in `wr_allow` is 0 leaves the entry and its last writer unchanged and is recorded with `log_denied` = 1. With `check_en` = 0, every signal is applied and `log_denied` is 0.
- R9: While the FIFO holds 16 records (the default depth), no `sig_ready` bit is set and no record is lost. `ovf_cnt` increases by one for each cycle in which the FIFO is full and any `sig_valid` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_valid | input | N_ENG | Signal request per engine |
| sig_ready | output | N_ENG | Signal request served this cycle |
| sig_handle | input | N_ENG*HANDLE_W | Handle per engine, engine e at bits e*HANDLE_W |
| sig_value | input | N_ENG*32 | New value per engine |
| sig_vmid | input | N_ENG*VMID_W | Writer VMID per engine |
| wait_valid | input | N_ENG | Wait request per engine |
| wait_handle | input | N_ENG*HANDLE_W | Handle waited on per engine |
| wait_seq | input | N_ENG*32 | Target sequence per engine |
| wait_done | output | N_ENG | Target reached |
| rd_handle | input | HANDLE_W | Read port handle |
| rd_value | output | 32 | Stored value of that entry |
| rd_eng | output | ENG_W | Last writer engine |
| rd_vmid | output | VMID_W | Last writer VMID |
| check_en | input | 1 | 1 selects checked mode, 0 selects fast mode |
| wr_allow | input | 2**VMID_W | Write mask, bit v for VMID v |
| log_valid | output | 1 | Record available |
| log_ready | input | 1 | Monitor takes the record |
| log_eng | output | ENG_W | Record engine |
| log_vmid | output | VMID_W | Record VMID |
| log_handle | output | HANDLE_W | Record handle |
| log_value | output | 32 | Record value |
| log_viol | output | 1 | Suspicious value |
| log_denied | output | 1 | Write refused by mask |
| ovf_cnt | output | OVF_W | Cycles stalled by a full FIFO |

## Verification
A corrupted table entry or last-writer field shows on `rd_value`, `rd_eng` and `rd_vmid` in the cycle after the write, and on `wait_done` in the same cycle. A wrong grant or a wrong FIFO pointer shows as a record out of order or with the wrong fields, as soon as the monitor pops it. A wrong flag shows on `log_viol` or `log_denied` in that same popped record. A wrong full count shows as a `sig_ready` bit set while 16 records are held, or as an `ovf_cnt` that drifts from the number of stalled cycles within one cycle.

// File: rtl/sot_pkg.sv
package sot_pkg;
   localparam int SEQ_W = 32;
   typedef logic [SEQ_W-1:0] seq_t;

   localparam seq_t POISON_ZERO = 32'h0000_0000;
   localparam seq_t POISON_ONES = 32'hFFFF_FFFF;
   localparam seq_t POISON_MARK = 32'hDEAD_BEEF;

   // values treated as evidence of a runaway writer
   function automatic logic seq_is_poison(input seq_t v);
      return (v == POISON_ZERO) || (v == POISON_ONES) || (v == POISON_MARK);
   endfunction
endpackage

// File: rtl/sot_prio_arb.sv
module sot_prio_arb #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   input  logic          en,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);
   // lowest index wins: scan from the top so the last hit is the lowest
   always_comb begin
      gnt = '0;
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (en && req[i]) begin
            gnt    = '0;
            gnt[i] = 1'b1;
            idx    = IW'(i);
            any    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/sot_log_fifo.sv
module sot_log_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          valid,
   output logic          full,
   output logic [LW-1:0] level
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sot_log_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [LW-1:0] cnt;
   logic          do_push, do_pop;

   assign valid   = (cnt != '0);
   assign full    = (cnt == LW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && valid;
   assign dout    = mem[rd_ptr];
   assign level   = cnt;

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/sot_table.sv
module sot_table
   import sot_pkg::*;
#(
   parameter int N_ENG    = 4,
   parameter int HANDLE_W = 4,
   parameter int VMID_W   = 4,
   localparam int ENG_W   = (N_ENG > 1) ? $clog2(N_ENG) : 1,
   localparam int NUM     = 1 << HANDLE_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [HANDLE_W-1:0]       w_handle,
   input  seq_t                      w_value,
   input  logic [ENG_W-1:0]          w_eng,
   input  logic [VMID_W-1:0]         w_vmid,
   output seq_t                      cur_value,
   input  logic [HANDLE_W-1:0]       rd_handle,
   output seq_t                      rd_value,
   output logic [ENG_W-1:0]          rd_eng,
   output logic [VMID_W-1:0]         rd_vmid,
   input  logic [N_ENG-1:0]          wait_valid,
   input  logic [N_ENG*HANDLE_W-1:0] wait_handle,
   input  logic [N_ENG*SEQ_W-1:0]    wait_seq,
   output logic [N_ENG-1:0]          wait_done
);
   seq_t              vals      [NUM];
   logic [ENG_W-1:0]  last_eng  [NUM];
   logic [VMID_W-1:0] last_vmid [NUM];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM; i++) begin
            vals[i]      <= '0;
            last_eng[i]  <= '0;
            last_vmid[i] <= '0;
         end
      end else if (we) begin
         vals[w_handle]      <= w_value;
         last_eng[w_handle]  <= w_eng;
         last_vmid[w_handle] <= w_vmid;
      end
   end

   assign cur_value = vals[w_handle];
   assign rd_value  = vals[rd_handle];
   assign rd_eng    = last_eng[rd_handle];
   assign rd_vmid   = last_vmid[rd_handle];

   // one comparator per engine: the wait is released once the target is reached
   generate
      for (genvar g = 0; g < N_ENG; g++) begin : g_wait
         logic [HANDLE_W-1:0] wh;
         seq_t                ws;
         assign wh           = wait_handle[g*HANDLE_W +: HANDLE_W];
         assign ws           = wait_seq[g*SEQ_W +: SEQ_W];
         assign wait_done[g] = wait_valid[g] && (vals[wh] >= ws);
      end
   endgenerate
endmodule

// File: rtl/sync_obj_table.sv
module sync_obj_table
   import sot_pkg::*;
#(
   parameter int N_ENG     = 4,
   parameter int HANDLE_W  = 4,
   parameter int VMID_W    = 4,
   parameter int LOG_DEPTH = 16,
   parameter int OVF_W     = 16,
   localparam int ENG_W    = (N_ENG > 1) ? $clog2(N_ENG) : 1,
   localparam int NVMID    = 1 << VMID_W,
   localparam int LVL_W    = $clog2(LOG_DEPTH) + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_ENG-1:0]          sig_valid,
   output logic [N_ENG-1:0]          sig_ready,
   input  logic [N_ENG*HANDLE_W-1:0] sig_handle,
   input  logic [N_ENG*32-1:0]       sig_value,
   input  logic [N_ENG*VMID_W-1:0]   sig_vmid,
   input  logic [N_ENG-1:0]          wait_valid,
   input  logic [N_ENG*HANDLE_W-1:0] wait_handle,
   input  logic [N_ENG*32-1:0]       wait_seq,
   output logic [N_ENG-1:0]          wait_done,
   input  logic [HANDLE_W-1:0]       rd_handle,
   output logic [31:0]               rd_value,
   output logic [ENG_W-1:0]          rd_eng,
   output logic [VMID_W-1:0]         rd_vmid,
   input  logic                      check_en,
   input  logic [NVMID-1:0]          wr_allow,
   output logic                      log_valid,
   input  logic                      log_ready,
   output logic [ENG_W-1:0]          log_eng,
   output logic [VMID_W-1:0]         log_vmid,
   output logic [HANDLE_W-1:0]       log_handle,
   output logic [31:0]               log_value,
   output logic                      log_viol,
   output logic                      log_denied,
   output logic [OVF_W-1:0]          ovf_cnt
);
   localparam int REC_W = ENG_W + VMID_W + HANDLE_W + SEQ_W + 2;

   generate
      if (N_ENG < 2 || N_ENG > 64) begin : g_bad_eng
         $error("sync_obj_table: N_ENG must lie in 2..64");
      end
      if (HANDLE_W < 1 || HANDLE_W > 10) begin : g_bad_handle
         $error("sync_obj_table: HANDLE_W must lie in 1..10");
      end
      if (VMID_W < 1 || VMID_W > 8) begin : g_bad_vmid
         $error("sync_obj_table: VMID_W must lie in 1..8");
      end
      if (OVF_W < 1) begin : g_bad_ovf
         $error("sync_obj_table: OVF_W must be positive");
      end
   endgenerate

   // per-engine views of the flat request buses
   logic [HANDLE_W-1:0] e_handle [N_ENG];
   seq_t                e_value  [N_ENG];
   logic [VMID_W-1:0]   e_vmid   [N_ENG];

   generate
      for (genvar g = 0; g < N_ENG; g++) begin : g_unpack
         assign e_handle[g] = sig_handle[g*HANDLE_W +: HANDLE_W];
         assign e_value[g]  = sig_value[g*SEQ_W +: SEQ_W];
         assign e_vmid[g]   = sig_vmid[g*VMID_W +: VMID_W];
      end
   endgenerate

   logic [N_ENG-1:0]    gnt;
   logic [ENG_W-1:0]    gnt_idx;
   logic                gnt_any;
   logic                log_full;
   logic [LVL_W-1:0]    log_level;

   sot_prio_arb #(.N(N_ENG)) arb_i (
      .req (sig_valid),
      .en  (!log_full),
      .gnt (gnt),
      .idx (gnt_idx),
      .any (gnt_any)
   );

   assign sig_ready = gnt;

   // selected request
   logic [HANDLE_W-1:0] s_handle;
   seq_t                s_value;
   logic [VMID_W-1:0]   s_vmid;
   seq_t                s_old;
   logic                s_viol, s_denied;

   assign s_handle = e_handle[gnt_idx];
   assign s_value  = e_value[gnt_idx];
   assign s_vmid   = e_vmid[gnt_idx];
   assign s_viol   = (s_value < s_old) || seq_is_poison(s_value);
   assign s_denied = check_en && !wr_allow[s_vmid];

   sot_table #(
      .N_ENG    (N_ENG),
      .HANDLE_W (HANDLE_W),
      .VMID_W   (VMID_W)
   ) table_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .we          (gnt_any && !s_denied),
      .w_handle    (s_handle),
      .w_value     (s_value),
      .w_eng       (gnt_idx),
      .w_vmid      (s_vmid),
      .cur_value   (s_old),
      .rd_handle   (rd_handle),
      .rd_value    (rd_value),
      .rd_eng      (rd_eng),
      .rd_vmid     (rd_vmid),
      .wait_valid  (wait_valid),
      .wait_handle (wait_handle),
      .wait_seq    (wait_seq),
      .wait_done   (wait_done)
   );

   logic [REC_W-1:0] rec_in, rec_out;
   assign rec_in = {gnt_idx, s_vmid, s_handle, s_value, s_viol, s_denied};

   sot_log_fifo #(.W(REC_W), .DEPTH(LOG_DEPTH)) log_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (gnt_any),
      .din   (rec_in),
      .pop   (log_ready),
      .dout  (rec_out),
      .valid (log_valid),
      .full  (log_full),
      .level (log_level)
   );

   assign {log_eng, log_vmid, log_handle, log_value, log_viol, log_denied} = rec_out;

   always_ff @(posedge clk) begin
      if (!rst_n)                     ovf_cnt <= '0;
      else if (log_full && |sig_valid) ovf_cnt <= ovf_cnt + 1'b1;
   end
endmodule

// File: rtl/sync_obj_table_chk.sv
module sync_obj_table_chk #(
   parameter int N_ENG     = 4,
   parameter int LOG_DEPTH = 16,
   parameter int OVF_W     = 16,
   localparam int LVL_W    = $clog2(LOG_DEPTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_ENG-1:0] sig_valid,
   input logic [N_ENG-1:0] sig_ready,
   input logic [LVL_W-1:0] log_level,
   input logic [OVF_W-1:0] ovf_cnt
);
   localparam logic [N_ENG-1:0] ONE_E = N_ENG'(1);
   localparam logic [OVF_W-1:0] ONE_O = OVF_W'(1);

   assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sig_ready));

   assert_lowest_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|sig_ready) |-> ((sig_valid & (sig_ready - ONE_E)) == '0));

   assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((sig_ready & ~sig_valid) == '0));

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (log_level == LVL_W'(LOG_DEPTH)) |-> (sig_ready == '0));

   assert_stall_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((log_level == LVL_W'(LOG_DEPTH)) && (|sig_valid)) |=>
         (ovf_cnt == $past(ovf_cnt) + ONE_O));
endmodule

bind sync_obj_table sync_obj_table_chk #(
   .N_ENG     (N_ENG),
   .LOG_DEPTH (LOG_DEPTH),
   .OVF_W     (OVF_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .sig_valid (sig_valid),
   .sig_ready (sig_ready),
   .log_level (log_level),
   .ovf_cnt   (ovf_cnt)
);

// File: tb/sync_obj_table_tb_top.sv
`timescale 1ns/1ps
module sync_obj_table_tb_top;
   localparam int N = 4, HW = 4, VW = 4, EW = 2, OW = 16, NH = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n;
   logic [N-1:0]    sig_valid, sig_ready, wait_valid, wait_done;
   logic [N*HW-1:0] sig_handle, wait_handle;
   logic [N*32-1:0] sig_value, wait_seq;
   logic [N*VW-1:0] sig_vmid;
   logic [HW-1:0]   rd_handle, log_handle;
   logic [31:0]     rd_value, log_value;
   logic [EW-1:0]   rd_eng, log_eng;
   logic [VW-1:0]   rd_vmid, log_vmid;
   logic            check_en, log_valid, log_ready, log_viol, log_denied;
   logic [15:0]     wr_allow;
   logic [OW-1:0]   ovf_cnt;

   sync_obj_table dut_i (.*);

   typedef struct {
      int unsigned eng, vmid, h;
      logic [31:0] v;
      bit          viol, den;
      string       req;
   } rec_t;

   rec_t        exp_q[$];
   int          checks = 0, errors = 0;
   bit          finished = 0;
   logic [31:0] m_val  [NH];
   int unsigned m_eng  [NH];
   int unsigned m_vmid [NH];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic rec_t serve(input int e, input int h, input logic [31:0] v,
                                  input int vm, input string req);
      rec_t r;
      r.eng = e; r.vmid = vm; r.h = h; r.v = v; r.req = req;
      r.viol = (v < m_val[h]) || v == 32'h0 || v == 32'hFFFF_FFFF || v == 32'hDEAD_BEEF;
      r.den  = check_en && !wr_allow[vm];
      if (!r.den) begin
         m_val[h] = v; m_eng[h] = e; m_vmid[h] = vm;
      end
      return r;
   endfunction

   task automatic set_sig(input int e, input int h, input logic [31:0] v, input int vm,
                          input bit on);
      sig_valid[e]           = on;
      sig_handle[e*HW +: HW] = HW'(h);
      sig_value[e*32 +: 32]  = v;
      sig_vmid[e*VW +: VW]   = VW'(vm);
   endtask

   // driver: request, wait for service, record what the monitor must see
   task automatic signal1(input int e, input int h, input logic [31:0] v, input int vm,
                          input string req);
      @(negedge clk);
      set_sig(e, h, v, vm, 1'b1);
      #1;
      while (!sig_ready[e]) begin
         @(negedge clk);
         #1;
      end
      exp_q.push_back(serve(e, h, v, vm, req));
      @(negedge clk);
      set_sig(e, h, v, vm, 1'b0);
   endtask

   task automatic check_entry(input int h, input string req);
      rd_handle = HW'(h);
      #1;
      chk(rd_value == m_val[h], req, "rd_value", rd_value, m_val[h]);
      chk(rd_eng == EW'(m_eng[h]) && rd_vmid == VW'(m_vmid[h]), req, "last writer",
          {rd_eng, rd_vmid}, {EW'(m_eng[h]), VW'(m_vmid[h])});
   endtask

   // monitor: pop and compare each record as the design hands it out
   always @(negedge clk) begin
      #1;
      if (rst_n && log_valid && log_ready && !finished) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6", "unexpected record", log_value, 0);
         end else begin
            rec_t r;
            r = exp_q.pop_front();
            chk({log_eng, log_vmid, log_handle, log_value, log_viol, log_denied} ==
                {EW'(r.eng), VW'(r.vmid), HW'(r.h), r.v, r.viol, r.den}, r.req, "record",
                {log_eng, log_vmid, log_handle, log_value, log_viol, log_denied},
                {EW'(r.eng), VW'(r.vmid), HW'(r.h), r.v, r.viol, r.den});
         end
      end
   end

   task automatic finish_run();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #400000;
      chk(1'b0, "R6", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      rst_n = 0; sig_valid = '0; sig_handle = '0; sig_value = '0; sig_vmid = '0;
      wait_valid = '0; wait_handle = '0; wait_seq = '0; rd_handle = '0;
      check_en = 0; wr_allow = '1; log_ready = 1;
      for (int i = 0; i < NH; i++) begin m_val[i] = 0; m_eng[i] = 0; m_vmid[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      check_entry(0, "R1");
      check_entry(15, "R1");
      chk(log_valid == 0 && sig_ready == 0, "R1", "log_valid,sig_ready",
          {log_valid, sig_ready}, 0);
      chk(ovf_cnt == 0, "R1", "ovf_cnt", ovf_cnt, 0);

      // R4 / R2 basic write and readback
      signal1(1, 3, 32'd5, 2, "R4");
      check_entry(3, "R4");
      check_entry(15, "R2");

      // R3 wait comparator
      wait_valid[2] = 1; wait_handle[2*HW +: HW] = 3; wait_seq[2*32 +: 32] = 5;
      #1 chk(wait_done[2] == 1, "R3", "equal target", wait_done[2], 1);
      wait_seq[2*32 +: 32] = 6;
      #1 chk(wait_done[2] == 0, "R3", "above target", wait_done[2], 0);
      wait_valid[2] = 0; wait_seq[2*32 +: 32] = 0;
      #1 chk(wait_done[2] == 0, "R3", "no request", wait_done[2], 0);
      wait_valid[2] = 1; wait_seq[2*32 +: 32] = 6;
      signal1(0, 3, 32'd6, 1, "R4");
      #1 chk(wait_done[2] == 1, "R3", "released after signal", wait_done[2], 1);
      wait_valid[2] = 0;

      // R7 suspicious values, still applied
      signal1(2, 3, 32'd4, 5, "R7");
      check_entry(3, "R7");
      signal1(3, 5, 32'hDEAD_BEEF, 1, "R7");
      signal1(3, 5, 32'hFFFF_FFFF, 1, "R7");
      signal1(1, 6, 32'h0, 2, "R7");
      check_entry(5, "R7");

      // R8 permission check
      check_en = 1; wr_allow[7] = 0;
      signal1(3, 7, 32'd100, 7, "R8");
      check_entry(7, "R8");
      signal1(2, 7, 32'd101, 1, "R8");
      check_entry(7, "R8");
      check_en = 0;
      signal1(3, 7, 32'd102, 7, "R8");
      check_entry(7, "R8");
      wr_allow = '1;

      // R5 three engines at once
      @(negedge clk);
      set_sig(1, 9, 32'd20, 1, 1); set_sig(2, 9, 32'd21, 2, 1); set_sig(3, 9, 32'd22, 3, 1);
      for (int k = 1; k <= 3; k++) begin
         #1 chk(sig_ready == N'(1 << k), "R5", "grant order", sig_ready, 1 << k);
         exp_q.push_back(serve(k, 9, 32'd19 + 32'(k), k, "R5"));
         @(negedge clk);
         sig_valid[k] = 0;
      end
      check_entry(9, "R5");

      // R9 full log holds off signals
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
      log_ready = 0;
      for (int i = 0; i < 16; i++) signal1(i % 4, 8, 32'd1000 + 32'(i), 0, "R9");
      set_sig(0, 8, 32'd2000, 0, 1);
      for (int i = 0; i < 3; i++) begin
         #1 chk(sig_ready == 0 && log_valid == 1, "R9", "stall while full",
                {sig_ready, log_valid}, 1);
         @(negedge clk);
      end
      #1 chk(ovf_cnt == 3, "R9", "ovf_cnt", ovf_cnt, 3);
      sig_valid[0] = 0;
      @(negedge clk);
      log_ready = 1;
      while (exp_q.size() != 0) @(negedge clk);
      signal1(0, 8, 32'd2000, 0, "R9");
      check_entry(8, "R9");

      repeat (4) @(negedge clk);
      #1 chk(log_valid == 0 && exp_q.size() == 0, "R6", "drained", log_valid, 0);
      chk(ovf_cnt == 3, "R9", "ovf_cnt held", ovf_cnt, 3);
      finish_run();
   end
endmodule